// File: doc/BRIEF.md
# Match-Driven Watchdog Timer

This block is a watchdog timer that software reaches through a small word-addressed register bus. A count register advances by one on every cycle in which the `tick` input is high and counting is enabled. When the count equals a programmed match value, the block can do any mix of four things:

- set a sticky interrupt flag;
- zero the count and stop counting;
- change an external match pin;
- start a reset pulse on an internal and/or an external reset output.

The reset pulse has a programmable length. A debug-halt input can freeze the count.

A sticky cause bit records that the block drove the internal reset. That bit is cleared only by the power-on reset `por_n`. Every other register is cleared by the system reset `rst_n`, which the system is expected to drive from the internal reset output. A counter-clear request takes several ticks to finish, so software polls the count until it reads zero. The bus is a plain single-cycle register port with no valid/ready handshake: a write takes effect on the clock edge where `bus_wr` is high, and read data is combinational while `bus_rd` is high. No back-pressure exists.

Top module: `match_watchdog`

## Requirements
- R1: After `por_n` and `rst_n` are released, all eight registers read 0, and `irq`, `match_pin`, `rst_int_o` and `rst_ext_o` are low.
- R2: Register word index is `bus_addr[4:2]`:
  - 0 is interrupt;
  - 1 is control (bit0 run, bit1 clear request / busy, bit2 debug freeze);
  - 2 is count;
  - 3 is match control;
  - 4 is match value;
  - 5 is pin mode;
  - 6 is pulse length;
  - 7 is cause.

  With run set, the count increases by one per clock with `tick` high, holds with `tick` low, and holds after control is written 0.
- R3: With control bit2 set, the count holds while `dbg_halt` is high. With bit2 clear, `dbg_halt` has no effect.
- R4: Writing control with bit1 set clears the run bit and starts a clear. The count holds its value and control bit1 reads 1 until the third tick after the write, at which the count becomes 0 and bit1 reads 0. Cycles without `tick` do not advance the clear.
- R5: A match event occurs on a counting tick while count equals match. From a cleared count, the event falls on the (M+1)-th counting tick. With match control bit0 set, the event sets interrupt bit0, which drives `irq`.
- R6: Writing interrupt bit0 with 1 clears it. Writing it with 0 leaves it unchanged.
- R7: With match control bit2 set, a match zeroes the count and clears the control run bit. With bit2 clear, counting continues past the match.
- R8: On a match, match control bit5 starts a pulse on `rst_int_o` and bit6 starts one on `rst_ext_o`. Each pulse is high for (pulse length + 6) ticks. The pulse length register is 16 bits.
- R9: Pin mode bits [5:4] set what a match does to `match_pin`: 0 keeps it, 1 drives it low, 2 drives it high, 3 toggles it.
- R10: Cause bit0 becomes 1 when the block starts an internal reset pulse. It is read-only, survives `rst_n`, and only `por_n` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | System reset, active low, clears all but the pulse generator and cause bit |
| tick | input | 1 | Count-enable strobe |
| dbg_halt | input | 1 | Debugger active |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, zero when `bus_rd` is low |
| irq | output | 1 | Match interrupt flag |
| match_pin | output | 1 | External match pin |
| rst_int_o | output | 1 | Internal reset pulse |
| rst_ext_o | output | 1 | External reset pulse |

## Verification
The in-line properties take for granted that `rst_n` may fall at any time but is released only while `por_n` is high. They also assume the pulse generator sees `por_n` whenever the rest of the block sees power-on. For that reason, the freeze, clear and write-one-to-clear checks are disabled while `rst_n` is low.

The stimulus changes every input on the falling clock edge and holds `bus_wr` for exactly one edge. It drops `tick` during every bus write, so the bench's arithmetic count of ticks matches the design's. It ties `rst_n` to the inverse of `rst_int_o`, as a system would, which lets the cause bit be seen surviving a real watchdog-driven reset.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
  // register word indices (bus_addr[4:2])
  localparam int unsigned IDX_INT   = 0;
  localparam int unsigned IDX_CTRL  = 1;
  localparam int unsigned IDX_CNT   = 2;
  localparam int unsigned IDX_MCTRL = 3;
  localparam int unsigned IDX_MATCH = 4;
  localparam int unsigned IDX_PIN   = 5;
  localparam int unsigned IDX_PLEN  = 6;
  localparam int unsigned IDX_CAUSE = 7;

  // control bits
  localparam int unsigned CTRL_RUN = 0;
  localparam int unsigned CTRL_CLR = 1;
  localparam int unsigned CTRL_DBG = 2;

  // match control bits
  localparam int unsigned MC_IRQ  = 0;
  localparam int unsigned MC_STOP = 2;
  localparam int unsigned MC_RINT = 5;
  localparam int unsigned MC_REXT = 6;
  localparam int unsigned MC_W    = 7;

  // pin mode field low bit
  localparam int unsigned PIN_LSB = 4;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'd0,
    PIN_LOW    = 2'd1,
    PIN_HIGH   = 2'd2,
    PIN_TOGGLE = 2'd3
  } pin_mode_e;
endpackage

// File: rtl/wdm_counter.sv
module wdm_counter #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned CLR_TICKS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run_en,
  input  logic             dbg_en,
  input  logic             dbg_halt,
  input  logic             clr_req,
  input  logic [CNT_W-1:0] match_val,
  input  logic             stop_on_match,
  output logic [CNT_W-1:0] count,
  output logic             clr_busy,
  output logic             match_evt
);
  localparam int unsigned CW = $clog2(CLR_TICKS + 1);

  logic [CW-1:0] clr_left;
  logic          halted;
  logic          step;
  logic          clr_last;

  assign clr_busy  = (clr_left != '0);
  assign halted    = dbg_en & dbg_halt;
  assign step      = tick & run_en & ~halted & ~clr_busy;
  assign match_evt = step & (count == match_val);
  assign clr_last  = clr_busy & tick & (clr_left == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      clr_left <= '0;
    end else begin
      if (clr_req) begin
        clr_left <= CW'(CLR_TICKS);
      end else if (clr_busy && tick) begin
        clr_left <= clr_left - CW'(1);
      end

      if (clr_last) begin
        count <= '0;
      end else if (match_evt && stop_on_match) begin
        count <= '0;
      end else if (step) begin
        count <= count + CNT_W'(1);
      end
    end
  end

  // R3: debug freeze holds the count
  p_halt_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !clr_busy) |=> $stable(count));

  // R4: during a clear the count only holds or drops to zero
  p_clear_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |=> (count == '0 || $stable(count)));

  // R2: nothing moves the count without a tick
  p_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
endmodule

// File: rtl/wdm_regs.sv
module wdm_regs
  import wdm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PLEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              clr_busy,
  input  logic              match_evt,
  input  logic              rst_cause,
  output logic              run_en,
  output logic              dbg_en,
  output logic              clr_req,
  output logic [CNT_W-1:0]  match_val,
  output logic              stop_on_match,
  output logic              trig,
  output logic              sel_int,
  output logic              sel_ext,
  output logic [PLEN_W-1:0] pulse_len,
  output logic              irq,
  output logic              match_pin
);
  logic [2:0]      idx;
  logic [MC_W-1:0] mctrl_q;
  pin_mode_e       pin_mode_q;
  logic            unused_addr;

  assign idx         = addr[4:2];
  assign unused_addr = ^addr[1:0];

  function automatic logic hit(input int unsigned i);
    return wr && (idx == 3'(i));
  endfunction

  assign clr_req       = hit(IDX_CTRL) && wdata[CTRL_CLR];
  assign stop_on_match = mctrl_q[MC_STOP];
  assign sel_int       = mctrl_q[MC_RINT];
  assign sel_ext       = mctrl_q[MC_REXT];
  assign trig          = match_evt && (sel_int || sel_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      run_en     <= 1'b0;
      dbg_en     <= 1'b0;
      mctrl_q    <= '0;
      match_val  <= '0;
      pin_mode_q <= PIN_KEEP;
      pulse_len  <= '0;
      match_pin  <= 1'b0;
    end else begin
      if (hit(IDX_INT) && wdata[0]) irq <= 1'b0;
      if (match_evt && mctrl_q[MC_IRQ]) irq <= 1'b1;

      if (hit(IDX_CTRL)) begin
        run_en <= wdata[CTRL_RUN];
        dbg_en <= wdata[CTRL_DBG];
      end
      if (match_evt && mctrl_q[MC_STOP]) run_en <= 1'b0;

      if (hit(IDX_MCTRL)) mctrl_q    <= wdata[MC_W-1:0];
      if (hit(IDX_MATCH)) match_val  <= wdata[CNT_W-1:0];
      if (hit(IDX_PIN))   pin_mode_q <= pin_mode_e'(wdata[PIN_LSB+1:PIN_LSB]);
      if (hit(IDX_PLEN))  pulse_len  <= wdata[PLEN_W-1:0];

      if (match_evt) begin
        unique case (pin_mode_q)
          PIN_LOW:    match_pin <= 1'b0;
          PIN_HIGH:   match_pin <= 1'b1;
          PIN_TOGGLE: match_pin <= ~match_pin;
          default:    match_pin <= match_pin;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (idx)
        3'(IDX_INT):   rdata = DATA_W'(irq);
        3'(IDX_CTRL):  rdata = DATA_W'({dbg_en, clr_busy, run_en});
        3'(IDX_CNT):   rdata = DATA_W'(count);
        3'(IDX_MCTRL): rdata = DATA_W'(mctrl_q);
        3'(IDX_MATCH): rdata = DATA_W'(match_val);
        3'(IDX_PIN):   rdata = DATA_W'({pin_mode_q, 4'b0000});
        3'(IDX_PLEN):  rdata = DATA_W'(pulse_len);
        default:       rdata = DATA_W'(rst_cause);
      endcase
    end
  end

  // R6: writing 0 to the interrupt bit leaves it alone
  p_w1c_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit(IDX_INT) && !wdata[0] && !match_evt) |=> $stable(irq));

  // R5: an enabled match raises the interrupt
  p_irq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mctrl_q[MC_IRQ]) |=> irq);

  // R7: a stopping match leaves the run bit clear
  p_stop_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mctrl_q[MC_STOP] && !hit(IDX_CTRL)) |=> !run_en);
endmodule

// File: rtl/wdm_pulse.sv
module wdm_pulse #(
  parameter int unsigned PLEN_W = 16,
  parameter int unsigned EXTRA  = 6
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              tick,
  input  logic              trig,
  input  logic              sel_int,
  input  logic              sel_ext,
  input  logic [PLEN_W-1:0] len,
  output logic              rst_int,
  output logic              rst_ext,
  output logic              cause
);
  localparam int unsigned REM_W = PLEN_W + 1;

  logic [REM_W-1:0] left;
  logic             int_q;
  logic             ext_q;
  logic             active;

  assign active  = (left != '0);
  assign rst_int = active & int_q;
  assign rst_ext = active & ext_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      left  <= '0;
      int_q <= 1'b0;
      ext_q <= 1'b0;
      cause <= 1'b0;
    end else if (trig && !active) begin
      left  <= REM_W'(len) + REM_W'(EXTRA);
      int_q <= sel_int;
      ext_q <= sel_ext;
      if (sel_int) cause <= 1'b1;
    end else if (active && tick) begin
      left <= left - REM_W'(1);
    end
  end

  // R8: a fresh pulse loads its full length
  p_pulse_load_r8: assert property (@(posedge clk) disable iff (!por_n)
    (trig && !active) |=> (left == REM_W'($past(len)) + REM_W'(EXTRA)));

  // R8: a running pulse does not restart and only moves on ticks
  p_pulse_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
    (active && !tick) |=> $stable(left));

  // R10: the cause bit is sticky until power-on reset
  p_cause_sticky_r10: assert property (@(posedge clk) disable iff (!por_n)
    cause |=> cause);
endmodule

// File: rtl/match_watchdog.sv
module match_watchdog #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned PLEN_W    = 16,
  parameter int unsigned CLR_TICKS = 3,
  parameter int unsigned EXTRA     = 6
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              dbg_halt,
  input  logic [4:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              match_pin,
  output logic              rst_int_o,
  output logic              rst_ext_o
);
  logic              blk_rst_n;
  logic [CNT_W-1:0]  count;
  logic              clr_busy;
  logic              match_evt;
  logic              cause;
  logic              run_en;
  logic              dbg_en;
  logic              clr_req;
  logic [CNT_W-1:0]  match_val;
  logic              stop_on_match;
  logic              trig;
  logic              sel_int;
  logic              sel_ext;
  logic [PLEN_W-1:0] pulse_len;

  assign blk_rst_n = rst_n & por_n;

  wdm_counter #(.CNT_W(CNT_W), .CLR_TICKS(CLR_TICKS)) u_cnt (
    .clk(clk), .rst_n(blk_rst_n), .tick(tick), .run_en(run_en),
    .dbg_en(dbg_en), .dbg_halt(dbg_halt), .clr_req(clr_req),
    .match_val(match_val), .stop_on_match(stop_on_match),
    .count(count), .clr_busy(clr_busy), .match_evt(match_evt)
  );

  wdm_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PLEN_W(PLEN_W)) u_regs (
    .clk(clk), .rst_n(blk_rst_n), .addr(bus_addr), .wdata(bus_wdata),
    .wr(bus_wr), .rd(bus_rd), .rdata(bus_rdata), .count(count),
    .clr_busy(clr_busy), .match_evt(match_evt), .rst_cause(cause),
    .run_en(run_en), .dbg_en(dbg_en), .clr_req(clr_req),
    .match_val(match_val), .stop_on_match(stop_on_match), .trig(trig),
    .sel_int(sel_int), .sel_ext(sel_ext), .pulse_len(pulse_len),
    .irq(irq), .match_pin(match_pin)
  );

  wdm_pulse #(.PLEN_W(PLEN_W), .EXTRA(EXTRA)) u_pulse (
    .clk(clk), .por_n(por_n), .tick(tick), .trig(trig),
    .sel_int(sel_int), .sel_ext(sel_ext), .len(pulse_len),
    .rst_int(rst_int_o), .rst_ext(rst_ext_o), .cause(cause)
  );
endmodule

// File: tb/match_watchdog_tb.sv
module match_watchdog_tb;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        tb_rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        dbg_halt = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq, match_pin, rst_int_o, rst_ext_o;
  logic        rst_n;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] rv;

  assign rst_n = tb_rst_n & ~rst_int_o;

  always #2.5 clk = ~clk;

  match_watchdog u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick), .dbg_halt(dbg_halt),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq(irq), .match_pin(match_pin),
    .rst_int_o(rst_int_o), .rst_ext_o(rst_ext_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    tick = 1'b0;
    bus_addr = 5'(idx * 4);
    bus_wdata = d;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    bus_addr = 5'(idx * 4);
    bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic clear_count();
    wr(1, 32'h2);
    tick = 1'b1;
    repeat (3) @(negedge clk);
    tick = 1'b0;
  endtask

  // runs with tick high until irq; returns ticks taken
  task automatic run_to_irq(output int n);
    n = 0;
    tick = 1'b1;
    while (!irq && n < 100) begin
      @(negedge clk);
      n++;
    end
    tick = 1'b0;
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0;
    tb_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    tb_rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    int exp_cnt;
    logic exp_pin;
    do_por();

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(i, rv);
      check("R1 register reset", rv, 32'h0);
    end
    check("R1 outputs reset", {28'h0, irq, match_pin, rst_int_o, rst_ext_o}, 32'h0);

    // R2 counting under an irregular tick pattern
    wr(4, 32'd1000);
    wr(1, 32'h1);
    exp_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      tick = (i % 3) != 0;
      @(negedge clk);
      if (tick) exp_cnt++;
    end
    tick = 1'b0;
    rd(2, rv);
    check("R2 count per tick", rv, 32'(exp_cnt));
    wr(1, 32'h0);
    tick = 1'b1;
    repeat (5) @(negedge clk);
    tick = 1'b0;
    rd(2, rv);
    check("R2 stopped count holds", rv, 32'(exp_cnt));

    // R3 debug freeze
    wr(1, 32'h5);
    dbg_halt = 1'b1;
    tick = 1'b1;
    repeat (5) @(negedge clk);
    rd(2, rv);
    check("R3 frozen while halted", rv, 32'(exp_cnt));
    dbg_halt = 1'b0;
    repeat (3) @(negedge clk);
    exp_cnt += 3;
    rd(2, rv);
    check("R3 resumes after halt", rv, 32'(exp_cnt));
    tick = 1'b0;
    wr(1, 32'h1);
    dbg_halt = 1'b1;
    tick = 1'b1;
    repeat (4) @(negedge clk);
    tick = 1'b0;
    dbg_halt = 1'b0;
    exp_cnt += 4;
    rd(2, rv);
    check("R3 halt ignored without bit2", rv, 32'(exp_cnt));

    // R4 multi-tick clear
    wr(1, 32'h2);
    rd(2, rv);
    check("R4 count held at request", rv, 32'(exp_cnt));
    rd(1, rv);
    check("R4 busy bit set", rv, 32'h2);
    repeat (4) @(negedge clk);
    rd(2, rv);
    check("R4 clear waits for ticks", rv, 32'(exp_cnt));
    tick = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      rd(2, rv);
      check("R4 clear progress", rv, (k < 3) ? 32'(exp_cnt) : 32'h0);
    end
    tick = 1'b0;
    rd(1, rv);
    check("R4 busy bit cleared", rv, 32'h0);

    // R5 / R7 / R6 sweep of match values with and without stop
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 2; s++) begin
        clear_count();
        wr(0, 32'h1);
        wr(4, 32'(m));
        wr(3, 32'h1 | 32'(s << 2));
        wr(1, 32'h1);
        run_to_irq(n);
        check("R5 ticks to match", 32'(n), 32'(m + 1));
        rd(2, rv);
        check("R7 count after match", rv, s ? 32'h0 : 32'(m + 1));
        rd(1, rv);
        check("R7 run bit after match", rv, s ? 32'h0 : 32'h1);
        wr(1, 32'h0);
        wr(0, 32'h0);
        check("R6 write 0 keeps irq", 32'(irq), 32'h1);
        wr(0, 32'h1);
        check("R6 write 1 clears irq", 32'(irq), 32'h0);
      end
    end

    // R9 pin modes: high, keep, low, toggle, toggle
    exp_pin = 1'b0;
    wr(4, 32'd2);
    wr(3, 32'h5);
    for (int step = 0; step < 5; step++) begin
      int mode;
      mode = (step == 0) ? 2 : (step == 1) ? 0 : (step == 2) ? 1 : 3;
      clear_count();
      wr(0, 32'h1);
      wr(5, 32'(mode << 4));
      wr(1, 32'h1);
      run_to_irq(n);
      case (mode)
        1: exp_pin = 1'b0;
        2: exp_pin = 1'b1;
        3: exp_pin = ~exp_pin;
        default: exp_pin = exp_pin;
      endcase
      check("R9 match pin mode", 32'(match_pin), 32'(exp_pin));
    end

    // R8 external-only pulse length sweep
    for (int l = 0; l < 4; l++) begin
      clear_count();
      wr(4, 32'd1);
      wr(6, 32'(l));
      wr(3, (32'h1 << 6) | 32'h4);
      wr(1, 32'h1);
      tick = 1'b1;
      n = 0;
      while (!rst_ext_o && n < 50) begin
        @(negedge clk);
        n++;
      end
      n = 0;
      while (rst_ext_o && n < 100) begin
        n++;
        @(negedge clk);
      end
      tick = 1'b0;
      check("R8 external pulse length", 32'(n), 32'(l + 6));
      check("R8 internal stays low", 32'(rst_int_o), 32'h0);
      rd(7, rv);
      check("R10 no cause from external only", rv, 32'h0);
    end

    // R8 / R10 longest internal+external pulse, resets the block
    clear_count();
    wr(4, 32'd3);
    wr(6, 32'hFFFF);
    wr(3, (32'h3 << 5) | 32'h4);
    wr(1, 32'h1);
    tick = 1'b1;
    n = 0;
    while (!rst_int_o && n < 50) begin
      @(negedge clk);
      n++;
    end
    check("R8 external pulse with internal", 32'(rst_ext_o), 32'h1);
    n = 0;
    while (rst_int_o && n < 70000) begin
      n++;
      @(negedge clk);
    end
    tick = 1'b0;
    check("R8 internal pulse length", 32'(n), 32'd65541);
    rd(7, rv);
    check("R10 cause set", rv, 32'h1);
    rd(6, rv);
    check("R10 block registers reset", rv, 32'h0);
    wr(7, 32'h0);
    rd(7, rv);
    check("R10 cause read-only", rv, 32'h1);
    @(negedge clk);
    tb_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    tb_rst_n = 1'b1;
    @(negedge clk);
    rd(7, rv);
    check("R10 cause survives rst_n", rv, 32'h1);
    do_por();
    rd(7, rv);
    check("R10 cause cleared by por", rv, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule